// File: doc/BRIEF.md
# Automatic Output Field Range Selector

This block looks at every 32-bit result that a convolver produces. It decides which 20-bit slice of that result should feed the 16-bit output stage. There are four candidate slices, each offset 4 bits below the previous one. The most significant slice covers bits 31:12, then bits 27:8, then bits 23:4, and finally bits 19:0. To choose among them, the block measures how many copies of the sign bit sit at the top of the result. It then picks the slice that drops those redundant copies without losing any magnitude.

The selection follows the peak magnitude seen so far. A larger result can move it to a more significant slice. A smaller result never moves it back.

A programming event clears the held choice to the least significant slice. While the convolver pipeline flushes, the block then ignores results until ten falling edges of the line-sync input have passed.

The held choice is always visible on the field indicator, whether automatic mode is on or off. A second output tells the output stage whether the held choice is currently in force.

Top module: `fld_range_sel`

## Requirements
- R1: After synchronous reset, `fld_ind` is 3 and `auto_sel` is 0, and the line-sync holdoff starts again from zero.
- R2: Field code k (0 = bits 31:12, 1 = bits 27:8, 2 = bits 23:4, 3 = bits 19:0) is derived from the result as follows. If the top 5 bits are not all equal, the code is 0. Otherwise, if the top 9 bits are not all equal, the code is 1. Otherwise, if the top 13 bits are not all equal, the code is 2. Otherwise the code is 3.
- R3: A result whose top 5 bits are not all identical always gives code 0. A result with exactly 5 identical top bits gives code 1.
- R4: Once armed, a valid result whose code is smaller than `fld_ind` sets `fld_ind` to that code on the next cycle. A valid result with an equal or larger code leaves `fld_ind` unchanged.
- R5: While `prog_act` is high, the cycle after shows `fld_ind` = 3 and `auto_sel` = 0, and the holdoff count restarts from zero.
- R6: After reset or a programming event, valid results are ignored until ten falling edges of `line_sync` have been counted. High-to-low transitions count; holding the line high does not. The count saturates at ten.
- R7: `fld_ind` tracks the selection identically whether `auto_en` is 0 or 1.
- R8: `auto_sel` is 1 exactly when `auto_en` is 1 and the holdoff of R6 has completed.
- R9: While `res_vld` is low, the value on `res_data` has no effect on `fld_ind`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| res_vld | input | 1 | Marks `res_data` as a valid convolver result |
| res_data | input | 32 | Two's-complement convolver result |
| line_sync | input | 1 | Line-sync pulse; its falling edges drive the holdoff count |
| prog_act | input | 1 | High while any control register is being written |
| auto_en | input | 1 | Enables automatic use of the held field |
| fld_ind | output | 2 | Held (would-be) field code, coded as in R2 |
| auto_sel | output | 1 | High when the held field is in force |

## Verification
A fault in the sign-group classifier shows up on `fld_ind` one cycle after a valid result whose code crosses a group boundary. Results with exactly 4, 5, 8, 9, 12 and 13 leading sign bits expose it at once. A wrong holdoff count shows in two ways. First, `auto_sel` rises on the wrong line-sync edge. Second, `fld_ind` leaves 3 while updates should still be blocked, which is visible one cycle after the first large result. A peak register that forgets or drops back shows as soon as a smaller result follows a larger one.

// File: rtl/fld_range_pkg.sv
package fld_range_pkg;

    // number of candidate output windows
    localparam int NUM_FLD = 4;

    // window codes, most significant first; priority order is behaviour
    typedef enum logic [1:0] {
        FLD_TOP    = 2'd0,
        FLD_UPPER  = 2'd1,
        FLD_LOWER  = 2'd2,
        FLD_BOTTOM = 2'd3
    } fld_e;

    // width of the sign group examined for window boundary k
    function automatic int grp_width(input int k, input int step);
        return step * (k + 1) + 1;
    endfunction

    // holdoff counter width for a given number of sync edges
    function automatic int hold_cw(input int lines);
        return $clog2(lines + 1);
    endfunction

endpackage

// File: rtl/frs_sign_class.sv
module frs_sign_class
    import fld_range_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int STEP_W = 4
) (
    input  logic [DATA_W-1:0] data,
    output fld_e              code
);

    // mixed[k]: the sign group for boundary k holds both 0 and 1
    logic [NUM_FLD-2:0] mixed;

    for (genvar k = 0; k < NUM_FLD - 1; k++) begin : g_grp
        localparam int GW = grp_width(k, STEP_W);
        logic [GW-1:0] top_bits;
        assign top_bits = data[DATA_W-1 -: GW];
        assign mixed[k] = !((&top_bits) || !(|top_bits));
    end

    // first mixed group from the top decides; none mixed -> bottom window
    always_comb begin
        code = FLD_BOTTOM;
        for (int k = NUM_FLD - 2; k >= 0; k--) begin
            if (mixed[k]) code = fld_e'(2'(k));
        end
    end

endmodule

// File: rtl/frs_sync_holdoff.sv
module frs_sync_holdoff
    import fld_range_pkg::*;
#(
    parameter int HOLD_LINES = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic line_sync,
    input  logic prog_act,
    output logic armed
);

    localparam int CW = hold_cw(HOLD_LINES);
    localparam logic [CW-1:0] CNT_DONE = CW'(HOLD_LINES);

    logic          sync_q;
    logic [CW-1:0] cnt;
    logic          sync_fall;

    assign sync_fall = sync_q && !line_sync;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 1'b0;
            cnt    <= '0;
        end else begin
            sync_q <= line_sync;
            if (prog_act)
                cnt <= '0;
            else if (sync_fall && cnt != CNT_DONE)
                cnt <= cnt + 1'b1;
        end
    end

    assign armed = (cnt == CNT_DONE);

endmodule

// File: rtl/frs_peak_hold.sv
module frs_peak_hold
    import fld_range_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic upd,
    input  fld_e cand,
    output fld_e peak
);

    always_ff @(posedge clk) begin
        if (rst || clr)
            peak <= FLD_BOTTOM;
        else if (upd && cand < peak)
            peak <= cand;
    end

endmodule

// File: rtl/fld_range_sel.sv
module fld_range_sel
    import fld_range_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int STEP_W     = 4,
    parameter int HOLD_LINES = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              res_vld,
    input  logic [DATA_W-1:0] res_data,
    input  logic              line_sync,
    input  logic              prog_act,
    input  logic              auto_en,
    output logic [1:0]        fld_ind,
    output logic              auto_sel
);

    fld_e cand;
    fld_e peak;
    logic armed;

    frs_sign_class #(
        .DATA_W (DATA_W),
        .STEP_W (STEP_W)
    ) u_class (
        .data (res_data),
        .code (cand)
    );

    frs_sync_holdoff #(
        .HOLD_LINES (HOLD_LINES)
    ) u_hold (
        .clk       (clk),
        .rst       (rst),
        .line_sync (line_sync),
        .prog_act  (prog_act),
        .armed     (armed)
    );

    frs_peak_hold u_peak (
        .clk  (clk),
        .rst  (rst),
        .clr  (prog_act),
        .upd  (res_vld && armed),
        .cand (cand),
        .peak (peak)
    );

    assign fld_ind  = peak;
    assign auto_sel = auto_en && armed;

endmodule

// File: rtl/fld_range_chk.sv
module fld_range_chk #(
    parameter int DATA_W     = 32,
    parameter int STEP_W     = 4,
    parameter int HOLD_LINES = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              res_vld,
    input logic [DATA_W-1:0] res_data,
    input logic              line_sync,
    input logic              prog_act,
    input logic              auto_en,
    input logic [1:0]        fld_ind,
    input logic              auto_sel
);

    int   c_cnt;
    logic c_sq;
    int   c_lead;
    int   c_cls;

    // independent count of falling sync edges since the last clear
    always_ff @(posedge clk) begin
        if (rst) begin
            c_cnt <= 0;
            c_sq  <= 1'b0;
        end else begin
            c_sq <= line_sync;
            if (prog_act)
                c_cnt <= 0;
            else if (c_sq && !line_sync && c_cnt < HOLD_LINES)
                c_cnt <= c_cnt + 1;
        end
    end

    // leading sign-bit count and the window it implies
    always_comb begin
        c_lead = 1;
        for (int i = DATA_W - 2; i >= 0; i--) begin
            if (res_data[i] == res_data[DATA_W-1] && c_lead == DATA_W - 1 - i)
                c_lead = c_lead + 1;
        end
        if (c_lead < STEP_W + 1)            c_cls = 0;
        else if (c_lead < 2 * STEP_W + 1)   c_cls = 1;
        else if (c_lead < 3 * STEP_W + 1)   c_cls = 2;
        else                                c_cls = 3;
    end

    AST_RST_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (fld_ind == 2'd3 && !auto_sel));                       // R1
    AST_TAKE_LARGER: assert property (@(posedge clk) disable iff (rst)
        (res_vld && !prog_act && c_cnt == HOLD_LINES && c_cls < int'(fld_ind))
        |=> (int'(fld_ind) == $past(c_cls)));                                 // R2
    AST_NO_DROP: assert property (@(posedge clk) disable iff (rst)
        !prog_act |=> (fld_ind <= $past(fld_ind)));                           // R4
    AST_PROG_CLEAR: assert property (@(posedge clk) disable iff (rst)
        prog_act |=> (fld_ind == 2'd3 && !auto_sel));                         // R5
    AST_HOLDOFF: assert property (@(posedge clk) disable iff (rst)
        (c_cnt < HOLD_LINES) |-> (fld_ind == 2'd3));                          // R6
    AST_AUTO_SEL: assert property (@(posedge clk) disable iff (rst)
        auto_sel == (auto_en && c_cnt == HOLD_LINES));                        // R8
    AST_IDLE_VLD: assert property (@(posedge clk) disable iff (rst)
        (!res_vld && !prog_act) |=> $stable(fld_ind));                        // R9

endmodule

bind fld_range_sel fld_range_chk #(
    .DATA_W     (DATA_W),
    .STEP_W     (STEP_W),
    .HOLD_LINES (HOLD_LINES)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .res_vld   (res_vld),
    .res_data  (res_data),
    .line_sync (line_sync),
    .prog_act  (prog_act),
    .auto_en   (auto_en),
    .fld_ind   (fld_ind),
    .auto_sel  (auto_sel)
);

// File: tb/sim_fld_range_sel.sv
`timescale 1ns/1ps
module sim_fld_range_sel;

    logic        clk = 1'b0;
    logic        rst;
    logic        res_vld;
    logic [31:0] res_data;
    logic        line_sync;
    logic        prog_act;
    logic        auto_en;
    logic [1:0]  fld_ind;
    logic        auto_sel;

    always #4 clk = ~clk;

    fld_range_sel u0 (
        .clk       (clk),
        .rst       (rst),
        .res_vld   (res_vld),
        .res_data  (res_data),
        .line_sync (line_sync),
        .prog_act  (prog_act),
        .auto_en   (auto_en),
        .fld_ind   (fld_ind),
        .auto_sel  (auto_sel)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference state built from the requirements
    int m_peak;
    int m_cnt;
    bit m_sq;

    // R2: window from the number of identical leading bits
    function automatic int exp_code(input logic [31:0] d);
        int n = 1;
        for (int i = 30; i >= 0; i--) begin
            if (d[i] != d[31]) break;
            n++;
        end
        if (n < 5)  return 0;
        if (n < 9)  return 1;
        if (n < 13) return 2;
        return 3;
    endfunction

    task automatic compare(input string req);
        bit exp_sel;
        exp_sel = auto_en && (m_cnt == 10);
        checks++;
        if (int'(fld_ind) != m_peak || auto_sel != exp_sel) begin
            fails++;
            $display("FAIL %s fld_ind=%0d exp=%0d auto_sel=%0d exp=%0d",
                     req, fld_ind, m_peak, auto_sel, exp_sel);
        end
    endtask

    task automatic step(input bit vld, input logic [31:0] d, input bit sync,
                        input bit prog, input bit en, input string req);
        bit fall;
        res_vld = vld; res_data = d; line_sync = sync; prog_act = prog; auto_en = en;
        @(posedge clk);
        fall = m_sq && !sync;
        if (prog) begin
            m_peak = 3;
            m_cnt  = 0;
        end else begin
            if (vld && m_cnt == 10 && exp_code(d) < m_peak) m_peak = exp_code(d);
            if (fall && m_cnt < 10) m_cnt++;
        end
        m_sq = sync;
        @(negedge clk);
        compare(req);
    endtask

    task automatic pulses(input int n, input bit en, input string req);
        for (int i = 0; i < n; i++) begin
            step(1'b0, 32'h0, 1'b1, 1'b0, en, req);
            step(1'b0, 32'h0, 1'b0, 1'b0, en, req);
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; res_vld = 1'b0; res_data = '0;
        line_sync = 1'b0; prog_act = 1'b0; auto_en = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_peak = 3; m_cnt = 0; m_sq = 1'b0;
        compare("R1");

        // R6: large results ignored while holding off
        step(1'b1, 32'h7FFF0000, 1'b0, 1'b0, 1'b1, "R6");
        pulses(9, 1'b1, "R6");
        step(1'b1, 32'h7FFF0000, 1'b0, 1'b0, 1'b1, "R6");
        pulses(1, 1'b1, "R8");

        // R2 / R3: classification boundaries
        step(1'b1, 32'h00000123, 1'b0, 1'b0, 1'b1, "R2");
        step(1'b1, 32'h00100000, 1'b0, 1'b0, 1'b1, "R2");
        step(1'b1, 32'h07FFFFFF, 1'b0, 1'b0, 1'b1, "R3");
        step(1'b1, 32'h00001000, 1'b0, 1'b0, 1'b1, "R4");
        step(1'b0, 32'h80000000, 1'b0, 1'b0, 1'b1, "R9");
        step(1'b1, 32'hF8000000, 1'b0, 1'b0, 1'b1, "R4");
        step(1'b1, 32'hF7FFFFFF, 1'b0, 1'b0, 1'b1, "R3");
        step(1'b1, 32'h00000000, 1'b0, 1'b0, 1'b1, "R4");

        // R5: programming clears and restarts holdoff
        step(1'b0, 32'h0, 1'b0, 1'b1, 1'b1, "R5");
        step(1'b1, 32'h80000000, 1'b0, 1'b0, 1'b1, "R5");
        pulses(9, 1'b1, "R6");
        for (int i = 0; i < 5; i++) step(1'b1, 32'h80000000, 1'b1, 1'b0, 1'b1, "R6");
        step(1'b1, 32'h80000000, 1'b0, 1'b0, 1'b1, "R6");

        // R7 / R8: indicator tracks while automatic mode is off
        step(1'b0, 32'h0, 1'b0, 1'b1, 1'b0, "R5");
        pulses(10, 1'b0, "R8");
        step(1'b1, 32'hFFFF0000, 1'b0, 1'b0, 1'b0, "R7");
        step(1'b1, 32'h00800000, 1'b0, 1'b0, 1'b0, "R7");
        pulses(3, 1'b0, "R6");

        // random mix: saturation, peak tracking, clears
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] d;
            bit sync, prog, en;
            d    = 32'($signed($urandom) >>> ($urandom % 32));
            sync = ($urandom % 3 == 0) ? ~line_sync : line_sync;
            prog = ($urandom % 150 == 0);
            en   = ($urandom % 10 == 0) ? ~auto_en : auto_en;
            step(1'($urandom % 2), d, sync, prog, en, "R4");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule